// File: doc/BRIEF.md
# Current Matrix Row-Column Decoder

This block turns a binary level into the on/off pattern for a rectangular array of identical unit current cells. The decoding is spread over two levels. Shared logic works out a status for each row and a column enable vector. A small gate in every cell then combines the status of its row with its column enable to decide whether that cell conducts.

The level is registered on one clock edge. The whole cell vector, with the row status, is registered on the next edge, so every cell changes in the same cycle. Cells fill in row-major order: row 0 fills from column 0 upward, then row 1, and so on. The number of cells that are on always equals the level. Levels above the number of cells are clamped to full scale.

Top module: `cur_matrix_decoder`

## Requirements
- R1: While reset is asserted and after it is released, until a nonzero level has passed through the pipeline, every cell output is 0 and every row status is off (2'b00).
- R2: A level present on `code_in` at clock edge N appears on `cells_on` and `row_state` after clock edge N+1, and stays there until a new level follows the same path.
- R3: The number of ones on `cells_on` equals min(level, ROWS*COLS).
- R4: Row r has status 2'b11 (full) when (r+1)*COLS <= level, 2'b00 (off) when r*COLS >= level, and 2'b01 (partial) otherwise. The value 2'b10 never appears. Row r's status is bits [2r+1:2r] of `row_state`.
- R5: At most one row has partial status at any time.
- R6: Bit k of `cells_on` belongs to row k/COLS and column k%COLS, and it is 1 exactly when k < level. In the partial row, column c is on exactly when c < level mod COLS.
- R7: A level greater than ROWS*COLS turns on every cell and marks every row full.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| code_in | input | CODE_W | Binary level to convert |
| cells_on | output | ROWS*COLS | Cell enables, row-major, bit r*COLS+c |
| row_state | output | 2*ROWS | Status per row, 2 bits each |

## Verification
The assertions check on every cycle that the number of lit cells matches the level registered one cycle before. They also check that row statuses only ever take legal codes, that rows fill in order with at most one partial row, and that full and off rows agree with their cells. Only the bench's scenarios can show the exact two-edge latency, the exact bit position of each lit cell, the fill of the partial row, and clamping of levels above full scale. It covers these with an exhaustive sweep and with abrupt jumps between distant levels.

// File: rtl/cmd_pkg.sv
package cmd_pkg;
  typedef enum logic [1:0] {
    ROW_OFF  = 2'b00,
    ROW_PART = 2'b01,
    ROW_FULL = 2'b11
  } row_state_e;
endpackage

// File: rtl/cmd_row_decoder.sv
module cmd_row_decoder #(
  parameter int ROWS  = 4,
  parameter int COLS  = 8,
  parameter int LVL_W = 6
) (
  input  logic [LVL_W-1:0]      level,
  output logic [ROWS-1:0][1:0]  status
);
  import cmd_pkg::*;
  localparam int CW = LVL_W + 1;

  logic [CW-1:0] level_ext;
  assign level_ext = {1'b0, level};

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    localparam int LO = r * COLS;
    localparam int HI = (r + 1) * COLS;
    always_comb begin
      if (level_ext >= CW'(HI))      status[r] = ROW_FULL;
      else if (level_ext > CW'(LO))  status[r] = ROW_PART;
      else                           status[r] = ROW_OFF;
    end
  end
endmodule

// File: rtl/cmd_col_decoder.sv
module cmd_col_decoder #(
  parameter int COLS  = 8,
  parameter int LVL_W = 6
) (
  input  logic [LVL_W-1:0] level,
  output logic [COLS-1:0]  col_en
);
  logic [LVL_W-1:0] rem;
  assign rem = level % LVL_W'(COLS);

  for (genvar c = 0; c < COLS; c++) begin : g_col
    assign col_en[c] = (rem > LVL_W'(c));
  end
endmodule

// File: rtl/cmd_cell_logic.sv
module cmd_cell_logic (
  input  logic [1:0] row_status,
  input  logic       col_en,
  output logic       cell_on
);
  import cmd_pkg::*;
  always_comb begin
    unique case (row_status)
      ROW_FULL: cell_on = 1'b1;
      ROW_PART: cell_on = col_en;
      default:  cell_on = 1'b0;
    endcase
  end
endmodule

// File: rtl/cur_matrix_decoder.sv
module cur_matrix_decoder #(
  parameter int ROWS   = 4,
  parameter int COLS   = 8,
  parameter int CODE_W = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CODE_W-1:0]    code_in,
  output logic [ROWS*COLS-1:0] cells_on,
  output logic [2*ROWS-1:0]    row_state
);
  import cmd_pkg::*;
  localparam int CELLS = ROWS * COLS;
  localparam int LVL_W = $clog2(CELLS + 1);

  logic [LVL_W-1:0]     level_d, level_q;
  logic [ROWS-1:0][1:0] rows_d, rows_q;
  logic [COLS-1:0]      col_en;
  logic [CELLS-1:0]     cells_d, cells_q;
  logic                 en_in;

  // Clock enable written out: the pipeline advances every cycle.
  assign en_in = 1'b1;

  // Saturate levels above full scale.
  always_comb begin
    if (code_in > CODE_W'(CELLS)) level_d = LVL_W'(CELLS);
    else                          level_d = code_in[LVL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     level_q <= '0;
    else if (en_in) level_q <= level_d;
  end

  cmd_row_decoder #(.ROWS(ROWS), .COLS(COLS), .LVL_W(LVL_W)) i_rows (
    .level(level_q), .status(rows_d)
  );

  cmd_col_decoder #(.COLS(COLS), .LVL_W(LVL_W)) i_cols (
    .level(level_q), .col_en(col_en)
  );

  for (genvar r = 0; r < ROWS; r++) begin : g_r
    for (genvar c = 0; c < COLS; c++) begin : g_c
      cmd_cell_logic i_cell (
        .row_status(rows_d[r]),
        .col_en    (col_en[c]),
        .cell_on   (cells_d[r*COLS+c])
      );
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cells_q <= '0;
      rows_q  <= '0;
    end else if (en_in) begin
      cells_q <= cells_d;
      rows_q  <= rows_d;
    end
  end

  assign cells_on  = cells_q;
  assign row_state = rows_q;

  // Assertions
  logic [ROWS-1:0] part_flags;
  for (genvar r = 0; r < ROWS; r++) begin : g_pf
    assign part_flags[r] = (rows_q[r] == ROW_PART);
  end

  assert_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cells_q) == int'($past(level_q)));

  assert_one_partial_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(part_flags));

  for (genvar r = 0; r < ROWS; r++) begin : g_chk
    assert_legal_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rows_q[r] != 2'b10);
    assert_full_row_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rows_q[r] == ROW_FULL) |-> (&cells_q[r*COLS +: COLS]));
    assert_off_row_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rows_q[r] == ROW_OFF) |-> (cells_q[r*COLS +: COLS] == '0));
    if (r > 0) begin : g_ord
      assert_fill_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rows_q[r] != ROW_OFF) |-> (rows_q[r-1] == ROW_FULL));
    end
  end
endmodule

// File: tb/test_cur_matrix_decoder.sv
`timescale 1ns/1ps
module test_cur_matrix_decoder;
  localparam int ROWS = 4, COLS = 8, CODE_W = 6, CELLS = ROWS * COLS;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [CODE_W-1:0] code_in = '0;
  logic [CELLS-1:0]  cells_on;
  logic [2*ROWS-1:0] row_state;

  cur_matrix_decoder #(.ROWS(ROWS), .COLS(COLS), .CODE_W(CODE_W)) i_cur_matrix_decoder (
    .clk(clk), .rst_n(rst_n), .code_in(code_in),
    .cells_on(cells_on), .row_state(row_state)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    int               due;
    int               lvl;
    logic [CELLS-1:0] cells;
    logic [2*ROWS-1:0] rows;
  } item_t;

  item_t q[$];
  int cyc = 0, tests = 0, fails = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Driver: apply one level at a negedge and push its expected result.
  task automatic drive(int v);
    item_t it;
    int lvl;
    @(negedge clk);
    code_in = CODE_W'(v);
    lvl = (v > CELLS) ? CELLS : v;
    it.lvl = lvl;
    it.due = cyc + 2;
    for (int k = 0; k < CELLS; k++) it.cells[k] = (k < lvl);
    for (int r = 0; r < ROWS; r++) begin
      if ((r + 1) * COLS <= lvl)  it.rows[2*r +: 2] = 2'b11;
      else if (r * COLS >= lvl)   it.rows[2*r +: 2] = 2'b00;
      else                        it.rows[2*r +: 2] = 2'b01;
    end
    q.push_back(it);
  endtask

  // Monitor: compare away from the edge once each item falls due (R2 latency).
  initial begin
    forever begin
      @(posedge clk);
      #1;
      while (q.size() > 0 && q[0].due == cyc) begin
        item_t it;
        int np;
        it = q.pop_front();
        check(cells_on == it.cells, it.lvl == CELLS ? "R6/R7" : "R6", "cells (R2 timing)", 64'(cells_on), 64'(it.cells));
        check(row_state == it.rows, "R4", "row_state", 64'(row_state), 64'(it.rows));
        check($countones(cells_on) == it.lvl, "R3", "count", 64'($countones(cells_on)), 64'(it.lvl));
        np = 0;
        for (int r = 0; r < ROWS; r++) if (row_state[2*r +: 2] == 2'b01) np++;
        check(np <= 1, "R5", "partial rows", 64'(np), 64'd1);
      end
    end
  end

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    code_in = 6'd20;
    repeat (3) @(negedge clk);
    check(cells_on == '0, "R1", "cells in reset", 64'(cells_on), 64'd0);
    check(row_state == '0, "R1", "rows in reset", 64'(row_state), 64'd0);
    code_in = '0;
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(cells_on == '0, "R1", "cells after reset", 64'(cells_on), 64'd0);
    // Exhaustive sweep, including levels above full scale (R7).
    for (int v = 0; v < (1 << CODE_W); v++) drive(v);
    // Abrupt jumps between distant levels.
    drive(32); drive(0); drive(17); drive(8); drive(7); drive(40);
    drive(31); drive(1); drive(24); drive(63); drive(9);
    // Hold a level to show it stays (R2).
    drive(9); drive(9);
    repeat (4) @(negedge clk);
    // Reset again mid-run (R1).
    rst_n = 1'b0;
    #1;
    check(cells_on == '0, "R1", "cells on re-reset", 64'(cells_on), 64'd0);
    check(row_state == '0, "R1", "rows on re-reset", 64'(row_state), 64'd0);
    check(q.size() == 0, "R2", "pending items", 64'(q.size()), 64'd0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule